// File: doc/BRIEF.md
# Multiplexed External Interrupt Source

This block merges three event inputs into a single interrupt request. Each input has its own status flag. The first is a general-purpose pin that can be armed for a falling edge or for a steady level of either polarity. The second is a serial receive line: a low level there marks the start of an incoming character. The third is a card-detect line that is watched for a chosen level, so that insertion or removal of a card can be reported.

All three inputs are asynchronous. They pass through a two-stage synchronizer before any detection. An enabled source that triggers in a cycle sets its own flag and also sets a shared pending flag. The pending flag is cleared by the acknowledge input from the interrupt controller. The request output reaches the controller only while both a group enable and a global enable are set.

The flags clear in different ways:
- The pin flag is cleared by acknowledge or by software.
- The receive and card flags are cleared by software alone.

When a set and a clear reach a flag in the same cycle, the set wins.

Top module: `ext_irq_mux`

## Requirements
- R1: While reset is held and right after it is released, all three source flags, the pending flag and the request output read 0.
- R2: With `pin_en_i`=1 and `pin_edge_mode_i`=1, a high-to-low transition of `pin_i` sets `pin_flag_o` once. Holding the pin low after that flag is acknowledged does not set it again.
- R3: With `pin_en_i`=1 and `pin_edge_mode_i`=0, `pin_flag_o` is set in every cycle in which the synchronized pin equals `pin_level_hi_i` (1 = active high, 0 = active low).
- R4: With `pin_en_i`=0, activity on `pin_i` sets neither `pin_flag_o` nor `pend_o`.
- R5: With `rx_en_i`=1, a low level on `rx_i` sets `rx_flag_o`. With `rx_en_i`=0, `rx_i` has no effect.
- R6: With `card_en_i`=1, `card_flag_o` is set while the synchronized `card_i` equals `card_level_hi_i`. With `card_en_i`=0, `card_i` has no effect.
- R7: `rx_flag_o` is cleared only by `sw_clr_i[1]`, and `card_flag_o` only by `sw_clr_i[2]`. `irq_ack_i` leaves both unchanged.
- R8: `pin_flag_o` is cleared by `irq_ack_i` or by `sw_clr_i[0]`.
- R9: `pend_o` is set in any cycle in which an enabled source triggers, and is cleared by `irq_ack_i`.
- R10: `irq_o` is high exactly when `pend_o`, `group_en_i` and `global_en_i` are all 1.
- R11: When a flag is set and cleared in the same cycle, the set wins and the flag reads 1.
- R12: A change on any input affects the flags at the third rising clock edge after it: two synchronizer edges and one flag edge. The synchronizer stages reset to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | General external event pin (asynchronous) |
| rx_i | input | 1 | Serial receive line (asynchronous) |
| card_i | input | 1 | Card-detect line (asynchronous) |
| pin_en_i | input | 1 | Enable for the pin source |
| pin_edge_mode_i | input | 1 | 1 = falling edge, 0 = level trigger for the pin |
| pin_level_hi_i | input | 1 | Active level of the pin in level mode |
| rx_en_i | input | 1 | Enable for the receive source |
| card_en_i | input | 1 | Enable for the card source |
| card_level_hi_i | input | 1 | Card-detect level that triggers |
| group_en_i | input | 1 | Enable for the shared vector |
| global_en_i | input | 1 | Global interrupt enable |
| sw_clr_i | input | 3 | Software clear: bit0 pin, bit1 receive, bit2 card flag |
| irq_ack_i | input | 1 | Acknowledge from the interrupt controller |
| pin_flag_o | output | 1 | Pin source status |
| rx_flag_o | output | 1 | Receive source status |
| card_flag_o | output | 1 | Card source status |
| pend_o | output | 1 | Combined pending flag |
| irq_o | output | 1 | Gated interrupt request |

## Verification
The bench holds the pin low after an acknowledged falling edge. A detector that tests level instead of transition would then set the flag again and break R2.

It also acknowledges and clears software flags while their sources are still active. A design that gave the clear priority would drop the event, which R11 forbids. A design that let acknowledge reach the receive or card flag would lose status that software still has to read.

Each input change is timed against the third rising edge after it. A missing or extra synchronizer stage shows up as a flag one cycle early or late.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  localparam int SRC_N = 3;

  typedef enum logic [1:0] {
    SRC_PIN  = 2'd0,
    SRC_RX   = 2'd1,
    SRC_CARD = 2'd2
  } src_e;

  typedef struct packed {
    logic pin_en;
    logic pin_edge;
    logic pin_hi;
    logic rx_en;
    logic card_en;
    logic card_hi;
  } eirq_cfg_t;
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int        W      = 3,
  parameter int        STAGES = 2,
  parameter logic      RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stg_d[s] = d_i;
      end else begin : g_next
        always_comb stg_d[s] = stg_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= {W{RST_VAL}};
        else        stg_q[s] <= stg_d[s];
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import eirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] sync_i,
  input  eirq_cfg_t        cfg_i,
  output logic [SRC_N-1:0] trig_o
);
  logic pin_prev_q;
  logic pin_prev_d;
  logic pin_fall;
  logic pin_hit;

  always_comb begin
    pin_prev_d = sync_i[SRC_PIN];
    pin_fall   = pin_prev_q & ~sync_i[SRC_PIN];
    pin_hit    = cfg_i.pin_edge ? pin_fall : (sync_i[SRC_PIN] == cfg_i.pin_hi);
    trig_o[SRC_PIN]  = cfg_i.pin_en & pin_hit;
    trig_o[SRC_RX]   = cfg_i.rx_en & ~sync_i[SRC_RX];
    trig_o[SRC_CARD] = cfg_i.card_en & (sync_i[SRC_CARD] == cfg_i.card_hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_prev_q <= 1'b1;
    else        pin_prev_q <= pin_prev_d;
  end
endmodule

// File: rtl/eirq_flag.sv
module eirq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic en;
  logic d;

  always_comb begin
    en = set_i | clr_i;
    d  = set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_o <= 1'b0;
    else if (en) q_o <= d;
  end
endmodule

// File: rtl/ext_irq_mux.sv
module ext_irq_mux
  import eirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic       rx_i,
  input  logic       card_i,
  input  logic       pin_en_i,
  input  logic       pin_edge_mode_i,
  input  logic       pin_level_hi_i,
  input  logic       rx_en_i,
  input  logic       card_en_i,
  input  logic       card_level_hi_i,
  input  logic       group_en_i,
  input  logic       global_en_i,
  input  logic [2:0] sw_clr_i,
  input  logic       irq_ack_i,
  output logic       pin_flag_o,
  output logic       rx_flag_o,
  output logic       card_flag_o,
  output logic       pend_o,
  output logic       irq_o
);
  eirq_cfg_t        cfg;
  logic [SRC_N-1:0] raw;
  logic [SRC_N-1:0] synced;
  logic [SRC_N-1:0] trig;
  logic [SRC_N-1:0] clr_vec;
  logic [SRC_N-1:0] flags;

  always_comb begin
    cfg.pin_en   = pin_en_i;
    cfg.pin_edge = pin_edge_mode_i;
    cfg.pin_hi   = pin_level_hi_i;
    cfg.rx_en    = rx_en_i;
    cfg.card_en  = card_en_i;
    cfg.card_hi  = card_level_hi_i;
    raw[SRC_PIN]  = pin_i;
    raw[SRC_RX]   = rx_i;
    raw[SRC_CARD] = card_i;
    clr_vec[SRC_PIN]  = sw_clr_i[SRC_PIN] | irq_ack_i;
    clr_vec[SRC_RX]   = sw_clr_i[SRC_RX];
    clr_vec[SRC_CARD] = sw_clr_i[SRC_CARD];
  end

  eirq_sync #(.W(SRC_N), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d_i (raw),
    .q_o (synced)
  );

  eirq_detect u_det (
    .clk (clk),
    .rst_n (rst_n),
    .sync_i (synced),
    .cfg_i (cfg),
    .trig_o (trig)
  );

  genvar i;
  generate
    for (i = 0; i < SRC_N; i++) begin : g_flag
      eirq_flag u_flag (
        .clk (clk),
        .rst_n (rst_n),
        .set_i (trig[i]),
        .clr_i (clr_vec[i]),
        .q_o (flags[i])
      );
    end
  endgenerate

  eirq_flag u_pend (
    .clk (clk),
    .rst_n (rst_n),
    .set_i (|trig),
    .clr_i (irq_ack_i),
    .q_o (pend_o)
  );

  assign pin_flag_o  = flags[SRC_PIN];
  assign rx_flag_o   = flags[SRC_RX];
  assign card_flag_o = flags[SRC_CARD];
  assign irq_o       = pend_o & group_en_i & global_en_i;
endmodule

// File: rtl/eirq_checker.sv
module eirq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] trig,
  input logic [2:0] sw_clr_i,
  input logic       irq_ack_i,
  input logic       rx_en_i,
  input logic       pin_flag_o,
  input logic       rx_flag_o,
  input logic       card_flag_o,
  input logic       pend_o
);
  assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag_o && !sw_clr_i[1] |=> rx_flag_o);

  assert_card_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    card_flag_o && !sw_clr_i[2] |=> card_flag_o);

  assert_ack_clears_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_i && !trig[0] |=> !pin_flag_o);

  assert_ack_clears_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_i && !(|trig) |=> !pend_o);

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig) |=> pend_o);

  assert_rx_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag_o) |-> $past(rx_en_i));
endmodule

bind ext_irq_mux eirq_checker u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .trig (trig),
  .sw_clr_i (sw_clr_i),
  .irq_ack_i (irq_ack_i),
  .rx_en_i (rx_en_i),
  .pin_flag_o (pin_flag_o),
  .rx_flag_o (rx_flag_o),
  .card_flag_o (card_flag_o),
  .pend_o (pend_o)
);

// File: tb/sim_ext_irq_mux.sv
module sim_ext_irq_mux;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b1, rx = 1'b1, card = 1'b1;
  logic pin_en = 0, pin_edge = 0, pin_hi = 0, rx_en = 0, card_en = 0, card_hi = 0;
  logic grp_en = 0, glb_en = 0, ack = 0;
  logic [2:0] clr = 3'b000;
  logic pin_flag, rx_flag, card_flag, pend, irq;

  int checks = 0;
  int errs = 0;
  int cycles = 0;
  bit cmp_on = 0;
  string cur_req = "R1";

  always #(CLK_P/2) clk = ~clk;

  ext_irq_mux u0 (
    .clk (clk), .rst_n (rst_n),
    .pin_i (pin), .rx_i (rx), .card_i (card),
    .pin_en_i (pin_en), .pin_edge_mode_i (pin_edge), .pin_level_hi_i (pin_hi),
    .rx_en_i (rx_en), .card_en_i (card_en), .card_level_hi_i (card_hi),
    .group_en_i (grp_en), .global_en_i (glb_en),
    .sw_clr_i (clr), .irq_ack_i (ack),
    .pin_flag_o (pin_flag), .rx_flag_o (rx_flag), .card_flag_o (card_flag),
    .pend_o (pend), .irq_o (irq)
  );

  // behavioural reference
  bit qp[$], qr[$], qc[$];
  bit m_prev, m_pf, m_rf, m_cf, m_pd;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qp = '{1'b1, 1'b1}; qr = '{1'b1, 1'b1}; qc = '{1'b1, 1'b1};
      m_prev = 1; m_pf = 0; m_rf = 0; m_cf = 0; m_pd = 0;
    end else begin
      bit tp, tr, tc;
      if (pin_edge) tp = pin_en && m_prev && !qp[0];
      else          tp = pin_en && (qp[0] == pin_hi);
      tr = rx_en && !qr[0];
      tc = card_en && (qc[0] == card_hi);
      m_pf = tp ? 1'b1 : ((ack || clr[0]) ? 1'b0 : m_pf);
      m_rf = tr ? 1'b1 : (clr[1] ? 1'b0 : m_rf);
      m_cf = tc ? 1'b1 : (clr[2] ? 1'b0 : m_cf);
      m_pd = (tp || tr || tc) ? 1'b1 : (ack ? 1'b0 : m_pd);
      m_prev = qp[0];
      void'(qp.pop_front()); qp.push_back(pin);
      void'(qr.pop_front()); qr.push_back(rx);
      void'(qc.pop_front()); qc.push_back(card);
    end
  end

  task automatic chk(string req, string name, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", req, name, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cmp_on) begin
      #(CLK_P/4);
      chk(cur_req, "pin_flag", pin_flag, m_pf);
      chk(cur_req, "rx_flag", rx_flag, m_rf);
      chk(cur_req, "card_flag", card_flag, m_cf);
      chk(cur_req, "pend", pend, m_pd);
      chk("R10", "irq", irq, m_pd & grp_en & glb_en);
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk) ack = 1;
    @(negedge clk) ack = 0;
  endtask

  task automatic pulse_clr(logic [2:0] v);
    @(negedge clk) clr = v;
    @(negedge clk) clr = 3'b000;
  endtask

  initial begin : watchdog
    wait (cycles > 100000);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1", "pin_flag in reset", pin_flag, 1'b0);
    chk("R1", "pend in reset", pend, 1'b0);
    chk("R1", "irq in reset", irq, 1'b0);
    @(negedge clk) rst_n = 1;
    cmp_on = 1;
    tick(2);
    chk("R1", "card_flag after reset", card_flag, 1'b0);
    grp_en = 1; glb_en = 1;

    // R4: pin disabled
    cur_req = "R4";
    @(negedge clk) pin = 0; tick(4);
    @(negedge clk) pin = 1; tick(4);
    chk("R4", "pin_flag disabled", pin_flag, 1'b0);
    chk("R4", "pend disabled", pend, 1'b0);

    // R2 and R12: falling edge and latency
    cur_req = "R2"; pin_en = 1; pin_edge = 1; tick(3);
    @(negedge clk) pin = 0;
    @(posedge clk); @(posedge clk); #1;
    chk("R12", "pin_flag before third edge", pin_flag, 1'b0);
    @(posedge clk); #1;
    chk("R12", "pin_flag at third edge", pin_flag, 1'b1);
    tick(3);
    pulse_ack(); tick(5);
    chk("R2", "no retrigger while low", pin_flag, 1'b0);
    chk("R9", "pend cleared by ack", pend, 1'b0);
    @(negedge clk) pin = 1; tick(4);
    @(negedge clk) pin = 0; tick(4);
    chk("R2", "second fall", pin_flag, 1'b1);

    // R8: software clear of pin flag
    cur_req = "R8"; pulse_clr(3'b001); tick(2);
    chk("R8", "sw clear pin", pin_flag, 1'b0);

    // R3 level mode active low, ack while active (R11)
    cur_req = "R3"; pin_edge = 0; pin_hi = 0; tick(4);
    chk("R3", "active-low level", pin_flag, 1'b1);
    cur_req = "R11"; pulse_ack(); tick(1);
    chk("R11", "set beats ack", pin_flag, 1'b1);
    cur_req = "R3";
    @(negedge clk) pin = 1; tick(4); pulse_ack(); tick(2);
    chk("R3", "inactive level cleared", pin_flag, 1'b0);
    @(negedge clk) pin_hi = 1; tick(2);
    chk("R3", "active-high level", pin_flag, 1'b1);
    @(negedge clk) pin_en = 0; pulse_ack(); tick(2);

    // R5 receive
    cur_req = "R5";
    @(negedge clk) rx = 0; tick(5);
    chk("R5", "rx ignored when disabled", rx_flag, 1'b0);
    @(negedge clk) rx_en = 1; tick(2);
    chk("R5", "rx low sets flag", rx_flag, 1'b1);
    cur_req = "R7"; pulse_ack(); tick(2);
    chk("R7", "ack keeps rx flag", rx_flag, 1'b1);
    cur_req = "R11"; pulse_clr(3'b010); tick(1);
    chk("R11", "rx set beats clear", rx_flag, 1'b1);
    cur_req = "R7";
    @(negedge clk) rx = 1; tick(4); pulse_clr(3'b010); tick(1);
    chk("R7", "sw clear rx", rx_flag, 1'b0);
    pulse_ack();

    // R6 card
    cur_req = "R6";
    @(negedge clk) card_hi = 0; tick(3);
    chk("R6", "card ignored when disabled", card_flag, 1'b0);
    @(negedge clk) card_en = 1; tick(3);
    chk("R6", "no match level", card_flag, 1'b0);
    @(negedge clk) card = 0; tick(4);
    chk("R6", "card removal level", card_flag, 1'b1);
    cur_req = "R7"; pulse_ack(); tick(1);
    @(negedge clk) card = 1; tick(4); pulse_ack(); tick(1);
    chk("R7", "ack keeps card flag", card_flag, 1'b1);
    pulse_clr(3'b100); tick(1);
    chk("R7", "sw clear card", card_flag, 1'b0);

    // R10 gating and R9 combined
    cur_req = "R10";
    @(negedge clk) glb_en = 0; card_hi = 1; tick(4);
    chk("R10", "global gate", irq, 1'b0);
    chk("R9", "pend from card", pend, 1'b1);
    @(negedge clk) glb_en = 1; grp_en = 0; tick(1);
    chk("R10", "group gate", irq, 1'b0);
    @(negedge clk) grp_en = 1; tick(1);
    chk("R10", "irq passes", irq, 1'b1);
    cur_req = "R9";
    @(negedge clk) card_en = 0; rx = 0; pin_en = 1; pin_edge = 1; pin = 0; tick(5);
    @(negedge clk) rx_en = 0; pin = 1; pulse_ack(); tick(4);
    chk("R9", "pend dropped after sources idle", pend, 1'b0);
    pulse_clr(3'b111); tick(3);

    cmp_on = 0;
    tick(1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule